// File: doc/BRIEF.md
# Variable-Length Nibble Message Link

This block moves a 32-bit value across a 4-bit bus. Each direction has its own channel. Every message opens with a length nibble that tells the receiver how many data nibbles follow. After it come only the significant nibbles of the value, least significant first. Leading zero nibbles are never sent, so an 8-bit value takes three bus cycles instead of nine, and a zero value takes a single cycle.

The top module holds one endpoint. The transmit half takes a parallel word and a send strobe. It shows a busy flag while it drives the outgoing bus, which carries a valid flag and a nibble. The receive half watches the incoming bus and rebuilds the word, filling every bit above the received nibbles with zero. It then pulses a done flag for one cycle. Two endpoints are joined by wiring one endpoint's outgoing bus to the other's incoming bus. Arbitration between several endpoints is handled elsewhere.

Top module: `nibble_msg_link`

## Requirements
- R1: The length nibble equals the number of nibbles from bit 0 up to and including the highest nonzero nibble of the word, or 0 for a zero word. It appears on the outgoing bus, with valid high, in the cycle after the clock edge that samples an accepted send strobe.
- R2: The data nibbles follow the length nibble on consecutive cycles, nibble 0 (bits 3:0) first. Valid stays high for exactly 1 + length cycles.
- R3: A zero word is sent as a single length nibble of 0 with no data nibbles.
- R4: A word whose top nibble is nonzero is sent with length 8 followed by all eight nibbles.
- R5: Busy is high from the edge that accepts a send until the last nibble has left the bus. A send strobe seen while busy is high has no effect on the message in progress and starts no further message.
- R6: While no message is being sent, the outgoing valid is low and the outgoing nibble is 0.
- R7: The receiver puts the rebuilt word on its output, with all bits above the received nibbles zero, and pulses done for exactly one cycle. This happens at the edge that samples the last data nibble. The word output holds its value until the next done.
- R8: An incoming length nibble of 0 produces done at the edge that samples it, with a word of 0.
- R9: An incoming length nibble from 9 to 15 is handled as 8.
- R10: After the length nibble, the receiver ignores cycles with incoming valid low. The message resumes with the next cycle that has valid high.
- R11: After reset, busy, outgoing valid, done and the received word are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tx_send_i | input | 1 | Send strobe, accepted only when not busy |
| tx_word_i | input | 32 | Word to send, sampled with an accepted strobe |
| tx_busy_o | output | 1 | Transmitter is driving a message |
| tx_valid_o | output | 1 | Outgoing bus beat is valid |
| tx_nib_o | output | 4 | Outgoing nibble |
| rx_valid_i | input | 1 | Incoming bus beat is valid |
| rx_nib_i | input | 4 | Incoming nibble |
| rx_word_o | output | 32 | Last rebuilt word |
| rx_done_o | output | 1 | One-cycle pulse when a word is complete |

## Verification
The transmitter never sends a length above 8 and never leaves a gap inside a message. Because of that, a loopback setup alone cannot exercise the clamping of R9 or the pause handling of R10. The bench therefore switches the receiver's input from the transmitter to beats it drives itself, and feeds in oversized headers and a message split by idle cycles. A second hard case is a send strobe landing mid-message or on the final nibble. Directed timing places the strobe in those cycles, and the bench then confirms that the bus goes quiet and stays quiet.

// File: rtl/nlink_pkg.sv
package nlink_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned NIB_W  = 4;
    localparam int unsigned NIBS   = WORD_W / NIB_W;
    localparam int unsigned LEN_W  = $clog2(NIBS + 1);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef enum logic {
        RX_HEAD = 1'b0,
        RX_BODY = 1'b1
    } rx_state_e;

    // Outgoing transmitter state held together.
    typedef struct packed {
        logic  valid;
        nib_t  nib;
        len_t  remain;
        word_t shreg;
    } tx_ctx_t;

    // Oversized length fields saturate at a full word.
    function automatic len_t clamp_len(input nib_t hdr);
        if (int'(hdr) > int'(NIBS))
            return len_t'(NIBS);
        return len_t'(hdr);
    endfunction
endpackage

// File: rtl/nlink_len_enc.sv
module nlink_len_enc
    import nlink_pkg::*;
(
    input  word_t word_i,
    output len_t  len_o
);
    logic [NIBS-1:0] nz;

    for (genvar g = 0; g < NIBS; g++) begin : g_nz
        assign nz[g] = |word_i[g*NIB_W +: NIB_W];
    end

    always_comb begin
        len_o = '0;
        for (int i = 0; i < NIBS; i++) begin
            if (nz[i])
                len_o = len_t'(i + 1);
        end
    end
endmodule

// File: rtl/nlink_tx.sv
module nlink_tx
    import nlink_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  send_i,
    input  word_t word_i,
    output logic  busy_o,
    output logic  bus_valid_o,
    output nib_t  bus_nib_o
);
    len_t    enc_len;
    tx_ctx_t ctx_q;
    logic    accept;

    nlink_len_enc u_enc (
        .word_i (word_i),
        .len_o  (enc_len)
    );

    assign accept = send_i && !ctx_q.valid;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctx_q <= '0;
        end else if (accept) begin
            ctx_q.valid  <= 1'b1;
            ctx_q.nib    <= nib_t'(enc_len);
            ctx_q.remain <= enc_len;
            ctx_q.shreg  <= word_i;
        end else if (ctx_q.valid && ctx_q.remain != '0) begin
            ctx_q.valid  <= 1'b1;
            ctx_q.nib    <= ctx_q.shreg[NIB_W-1:0];
            ctx_q.remain <= ctx_q.remain - 1'b1;
            ctx_q.shreg  <= ctx_q.shreg >> NIB_W;
        end else begin
            ctx_q.valid  <= 1'b0;
            ctx_q.nib    <= '0;
            ctx_q.remain <= '0;
        end
    end

    assign busy_o      = ctx_q.valid;
    assign bus_valid_o = ctx_q.valid;
    assign bus_nib_o   = ctx_q.nib;

    p_accept_starts_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (send_i && !busy_o) |=> (busy_o && bus_valid_o));

    p_frame_contig_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_valid_o && ctx_q.remain != '0) |=> bus_valid_o);

    p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !bus_valid_o |-> (bus_nib_o == '0));

    p_hdr_range_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(bus_valid_o) |-> (int'(bus_nib_o) <= int'(NIBS)));

    p_top_nib_nonzero_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_valid_o && ctx_q.remain == '0 && !$rose(bus_valid_o)) |-> (bus_nib_o != '0));
endmodule

// File: rtl/nlink_rx.sv
module nlink_rx
    import nlink_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  bus_valid_i,
    input  nib_t  bus_nib_i,
    output word_t word_o,
    output logic  done_o
);
    rx_state_e state_q;
    len_t      need_q;
    len_t      got_q;
    word_t     acc_q;
    word_t     word_q;
    logic      done_q;
    len_t      hdr_len;
    word_t     acc_ins;
    logic      last_beat;

    assign hdr_len   = clamp_len(bus_nib_i);
    assign acc_ins   = acc_q | (word_t'(bus_nib_i) << (NIB_W * int'(got_q)));
    assign last_beat = (len_t'(got_q + 1'b1) == need_q);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= RX_HEAD;
            need_q  <= '0;
            got_q   <= '0;
            acc_q   <= '0;
            word_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                RX_HEAD: begin
                    if (bus_valid_i) begin
                        if (hdr_len == '0) begin
                            done_q <= 1'b1;
                            word_q <= '0;
                        end else begin
                            need_q  <= hdr_len;
                            got_q   <= '0;
                            acc_q   <= '0;
                            state_q <= RX_BODY;
                        end
                    end
                end
                RX_BODY: begin
                    if (bus_valid_i) begin
                        acc_q <= acc_ins;
                        got_q <= got_q + 1'b1;
                        if (last_beat) begin
                            done_q  <= 1'b1;
                            word_q  <= acc_ins;
                            state_q <= RX_HEAD;
                        end
                    end
                end
                default: state_q <= RX_HEAD;
            endcase
        end
    end

    assign word_o = word_q;
    assign done_o = done_q;

    p_done_after_beat_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> $past(bus_valid_i));

    p_word_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !done_o |-> $stable(word_o));

    p_zero_header_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == RX_HEAD && bus_valid_i && bus_nib_i == '0) |=> (done_o && word_o == '0));

    p_gap_pause_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == RX_BODY && !bus_valid_i) |=> ($stable(got_q) && !done_o));

    p_need_clamped_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == RX_BODY) |-> (int'(need_q) <= int'(NIBS)));
endmodule

// File: rtl/nibble_msg_link.sv
module nibble_msg_link
    import nlink_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        tx_send_i,
    input  logic [31:0] tx_word_i,
    output logic        tx_busy_o,
    output logic        tx_valid_o,
    output logic [3:0]  tx_nib_o,
    input  logic        rx_valid_i,
    input  logic [3:0]  rx_nib_i,
    output logic [31:0] rx_word_o,
    output logic        rx_done_o
);
    nlink_tx u_tx (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .send_i      (tx_send_i),
        .word_i      (tx_word_i),
        .busy_o      (tx_busy_o),
        .bus_valid_o (tx_valid_o),
        .bus_nib_o   (tx_nib_o)
    );

    nlink_rx u_rx (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .bus_valid_i (rx_valid_i),
        .bus_nib_i   (rx_nib_i),
        .word_o      (rx_word_o),
        .done_o      (rx_done_o)
    );

    p_reset_quiet_r11: assert property (@(posedge clk_i)
        $past(rst_i) |-> (!tx_busy_o && !tx_valid_o && !rx_done_o && rx_word_o == '0));
endmodule

// File: tb/nibble_msg_link_tb.sv
module nibble_msg_link_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        send = 1'b0;
    logic [31:0] data = '0;
    logic        busy, tvalid, rdone;
    logic [3:0]  tnib;
    logic [31:0] rword;
    logic        lb = 1'b1;
    logic        dvalid = 1'b0;
    logic [3:0]  dnib = '0;
    logic        rvalid;
    logic [3:0]  rnib;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    assign rvalid = lb ? tvalid : dvalid;
    assign rnib   = lb ? tnib   : dnib;

    nibble_msg_link dut_i (
        .clk_i(clk), .rst_i(rst), .tx_send_i(send), .tx_word_i(data),
        .tx_busy_o(busy), .tx_valid_o(tvalid), .tx_nib_o(tnib),
        .rx_valid_i(rvalid), .rx_nib_i(rnib), .rx_word_o(rword), .rx_done_o(rdone)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int sig_len(input logic [31:0] w);
        int n = 0;
        for (int i = 0; i < 8; i++)
            if (w[4*i +: 4] != 4'h0) n = i + 1;
        return n;
    endfunction

    // Loopback send: checks the bus beat by beat, then the receiver result.
    task automatic send_and_check(input logic [31:0] w, input string req);
        int len = sig_len(w);
        lb = 1'b1;
        @(negedge clk); send = 1'b1; data = w;
        @(negedge clk); send = 1'b0;
        check({req, " R1 header valid"}, {31'd0, tvalid}, 32'd1);
        check({req, " R1 header value"}, {28'd0, tnib}, len);
        check({req, " R5 busy"}, {31'd0, busy}, 32'd1);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            check({req, " R2 data valid"}, {31'd0, tvalid}, 32'd1);
            check({req, " R2 data nibble"}, {28'd0, tnib}, {28'd0, w[4*i +: 4]});
        end
        @(negedge clk);
        check({req, " R6 valid low after frame"}, {31'd0, tvalid}, 32'd0);
        check({req, " R6 nibble zero idle"}, {28'd0, tnib}, 32'd0);
        check({req, " R5 busy low after frame"}, {31'd0, busy}, 32'd0);
        check({req, " R7 done"}, {31'd0, rdone}, 32'd1);
        check({req, " R7 word"}, rword, w);
        @(negedge clk);
        check({req, " R7 done one cycle"}, {31'd0, rdone}, 32'd0);
        check({req, " R7 word held"}, rword, w);
    endtask

    task automatic drive(input logic v, input logic [3:0] n);
        @(negedge clk); dvalid = v; dnib = n;
    endtask

    task automatic t_reset;
        check("R11 busy", {31'd0, busy}, 32'd0);
        check("R11 valid", {31'd0, tvalid}, 32'd0);
        check("R11 done", {31'd0, rdone}, 32'd0);
        check("R11 word", rword, 32'd0);
    endtask

    task automatic t_busy_ignore;
        logic [31:0] a = 32'h0000_4C7A;
        lb = 1'b1;
        @(negedge clk); send = 1'b1; data = a;
        @(negedge clk);
        check("R5 header during strobe test", {28'd0, tnib}, 32'd4);
        send = 1'b1; data = 32'h0000_0001;
        @(negedge clk); send = 1'b0;
        check("R5 nibble0 unaffected", {28'd0, tnib}, 32'hA);
        @(negedge clk);
        check("R5 nibble1 unaffected", {28'd0, tnib}, 32'h7);
        @(negedge clk);
        check("R5 nibble2 unaffected", {28'd0, tnib}, 32'hC);
        @(negedge clk);
        check("R5 nibble3 unaffected", {28'd0, tnib}, 32'h4);
        check("R5 busy on last nibble", {31'd0, busy}, 32'd1);
        send = 1'b1; data = 32'h0000_0002;
        @(negedge clk); send = 1'b0;
        check("R5 no restart from late strobe", {31'd0, tvalid}, 32'd0);
        check("R5 rx word is first message", rword, a);
        @(negedge clk);
        check("R5 bus stays quiet", {31'd0, tvalid}, 32'd0);
        check("R5 busy stays low", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_rx_zero_header;
        lb = 1'b0;
        drive(1'b1, 4'h0);
        drive(1'b0, 4'h0);
        check("R8 done on zero header", {31'd0, rdone}, 32'd1);
        check("R8 word zero", rword, 32'd0);
    endtask

    task automatic t_rx_clamp;
        lb = 1'b0;
        drive(1'b1, 4'hC);
        for (int i = 0; i < 8; i++) drive(1'b1, 4'(i + 1));
        drive(1'b0, 4'h0);
        check("R9 done after eight nibbles", {31'd0, rdone}, 32'd1);
        check("R9 word from clamped header", rword, 32'h8765_4321);
        drive(1'b1, 4'h0);
        drive(1'b0, 4'h0);
        check("R9 receiver back at header", {31'd0, rdone}, 32'd1);
    endtask

    task automatic t_rx_gap;
        lb = 1'b0;
        drive(1'b1, 4'h3);
        drive(1'b1, 4'h5);
        drive(1'b0, 4'hF);
        check("R10 no done during gap", {31'd0, rdone}, 32'd0);
        drive(1'b1, 4'h9);
        drive(1'b0, 4'hE);
        check("R10 no done before final nibble", {31'd0, rdone}, 32'd0);
        drive(1'b1, 4'h2);
        drive(1'b0, 4'h0);
        check("R10 done after gap", {31'd0, rdone}, 32'd1);
        check("R10 word zero-extended", rword, 32'h0000_0295);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        send_and_check(32'h0000_00A5, "R1 byte");
        send_and_check(32'h0000_0000, "R3 zero");
        send_and_check(32'hF000_0001, "R4 full");
        send_and_check(32'h0010_0000, "R2 interior zeros");
        send_and_check(32'h0000_0007, "R1 single nibble");
        t_busy_ignore();
        t_rx_zero_header();
        t_rx_clamp();
        t_rx_gap();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule